// File: doc/BRIEF.md
# Integer Arithmetic and Compare Unit

This block is the integer add, subtract and compare slice of a 64-bit execution pipe. A 7-bit function code picks the operation. Operand A comes from a register. Operand B comes from either a register or a zero-extended 8-bit literal, and that choice is made upstream. The unit adds or subtracts in two widths: a 32-bit "longword" form and a full 64-bit "quadword" form. In the scaled forms, A is first shifted left by 2 or 3. Four trapping codes also report signed overflow.

Beside the arithmetic, the unit makes signed and unsigned magnitude compares and an equality test, each giving a 0 or 1 result. It also makes a parallel byte compare that gives one mask bit per byte lane. A function code outside the defined set raises an illegal-function flag and yields a zero result. All three outputs are registered once: they show the operation presented in the previous cycle.

Top module: `int_arith_unit`

## Requirements
- R1: Codes 0x00 (32-bit) and 0x20 (64-bit) give A+B. The 32-bit form uses only bits 31:0 of each operand and sign-extends bit 31 of the 32-bit sum into bits 63:32.
- R2: Codes 0x09 (32-bit) and 0x29 (64-bit) give A-B, with the same width and sign-extension rules as R1.
- R3: The scaled codes first shift A left by a fixed amount and then add or subtract B, with the width rules of R1:
  - shift by 2: 0x02 (32-bit add), 0x22 (64-bit add), 0x0B (32-bit subtract), 0x2B (64-bit subtract);
  - shift by 3: 0x12 (32-bit add), 0x32 (64-bit add), 0x1B (32-bit subtract), 0x3B (64-bit subtract);
  - bits shifted out of the top are lost.
- R4: Codes 0x40 (32-bit) and 0x60 (64-bit) add like R1 and still deliver the sum. They set the overflow flag when A and B have equal sign bits and the sum's sign bit differs from A's. The sign bit is bit 31 for the 32-bit form and bit 63 for the 64-bit form.
- R5: Codes 0x49 (32-bit) and 0x69 (64-bit) subtract like R2 and still deliver the difference. They set the overflow flag when the sign bits of A and B differ and the difference's sign bit differs from A's.
- R6: Code 0x4D gives 1 when A < B as signed 64-bit numbers, else 0. Code 0x6D gives 1 when A <= B as signed 64-bit numbers, else 0.
- R7: The following codes give 1 when their test holds, else 0:
  - 0x2D: A equals B;
  - 0x1D: A < B as unsigned 64-bit numbers;
  - 0x3D: A <= B as unsigned 64-bit numbers.
- R8: Code 0x0F sets result bit i (i = 0..7) when unsigned byte i of A (bits 8i+7:8i) is greater than or equal to byte i of B. Result bits 63:8 are zero.
- R9: Any code not named in R1 to R8 drives illegal to 1, the result to zero and overflow to 0. A defined code drives illegal to 0.
- R10: Result, overflow and illegal update one clock after the inputs are sampled. While synchronous reset is high, all three are zero. The overflow flag is 0 for every code other than 0x40, 0x49, 0x60 and 0x69.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_i | input | 7 | Function code |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B (register or widened literal) |
| result_o | output | 64 | Registered result |
| ovf_o | output | 1 | Registered overflow-trap flag |
| illegal_o | output | 1 | Registered illegal-function flag |

## Verification
Every result of this unit, including the overflow and illegal flags, is due exactly one rising edge after the code and operands are applied. The bench drives each vector on a falling edge and waits through one rising edge. It then compares all three outputs on the next falling edge, so the sample always lands on the cycle in which that vector's outputs are held. One directed check also reads the outputs before that edge, to confirm they still show the earlier operation. During reset, the bench applies a stimulus that would otherwise overflow and confirms that the outputs stay zero.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

    typedef enum logic [2:0] {
        OP_ARITH,
        OP_EQ,
        OP_SLT,
        OP_SLE,
        OP_ULT,
        OP_ULE,
        OP_BYTEGE,
        OP_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic       sub;     // subtract instead of add
        logic       narrow;  // 32-bit form with sign extension
        logic [1:0] shamt;   // left shift applied to A
        logic       trap;    // report signed overflow
    } op_ctl_t;

    localparam int FUNC_W = 7;

    function automatic op_ctl_t arith_ctl(input logic sub, input logic narrow,
                                          input logic [1:0] shamt, input logic trap);
        op_ctl_t c;
        c.kind   = OP_ARITH;
        c.sub    = sub;
        c.narrow = narrow;
        c.shamt  = shamt;
        c.trap   = trap;
        return c;
    endfunction

    function automatic op_ctl_t decode_func(input logic [FUNC_W-1:0] f);
        op_ctl_t c;
        c = '0;
        c.kind = OP_BAD;
        case (f)
            7'h00: c = arith_ctl(1'b0, 1'b1, 2'd0, 1'b0);
            7'h40: c = arith_ctl(1'b0, 1'b1, 2'd0, 1'b1);
            7'h02: c = arith_ctl(1'b0, 1'b1, 2'd2, 1'b0);
            7'h12: c = arith_ctl(1'b0, 1'b1, 2'd3, 1'b0);
            7'h20: c = arith_ctl(1'b0, 1'b0, 2'd0, 1'b0);
            7'h60: c = arith_ctl(1'b0, 1'b0, 2'd0, 1'b1);
            7'h22: c = arith_ctl(1'b0, 1'b0, 2'd2, 1'b0);
            7'h32: c = arith_ctl(1'b0, 1'b0, 2'd3, 1'b0);
            7'h09: c = arith_ctl(1'b1, 1'b1, 2'd0, 1'b0);
            7'h49: c = arith_ctl(1'b1, 1'b1, 2'd0, 1'b1);
            7'h0B: c = arith_ctl(1'b1, 1'b1, 2'd2, 1'b0);
            7'h1B: c = arith_ctl(1'b1, 1'b1, 2'd3, 1'b0);
            7'h29: c = arith_ctl(1'b1, 1'b0, 2'd0, 1'b0);
            7'h69: c = arith_ctl(1'b1, 1'b0, 2'd0, 1'b1);
            7'h2B: c = arith_ctl(1'b1, 1'b0, 2'd2, 1'b0);
            7'h3B: c = arith_ctl(1'b1, 1'b0, 2'd3, 1'b0);
            7'h2D: c.kind = OP_EQ;
            7'h4D: c.kind = OP_SLT;
            7'h6D: c.kind = OP_SLE;
            7'h1D: c.kind = OP_ULT;
            7'h3D: c.kind = OP_ULE;
            7'h0F: c.kind = OP_BYTEGE;
            default: c.kind = OP_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
    import ialu_pkg::*;
(
    input  logic [FUNC_W-1:0] func_i,
    output op_ctl_t           ctl_o
);

    always_comb ctl_o = decode_func(func_i);

endmodule

// File: rtl/ialu_addsub.sv
module ialu_addsub
    import ialu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LONG_W = 32
) (
    input  op_ctl_t           ctl_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o
);

    localparam int EXT_W = DATA_W - LONG_W;

    logic [DATA_W-1:0] a_sc;
    logic [DATA_W-1:0] raw;
    logic              sa, sb, sr;

    always_comb begin
        a_sc = a_i << ctl_i.shamt;
        raw  = ctl_i.sub ? (a_sc - b_i) : (a_sc + b_i);
        if (ctl_i.narrow) begin
            sum_o = {{EXT_W{raw[LONG_W-1]}}, raw[LONG_W-1:0]};
            sa    = a_sc[LONG_W-1];
            sb    = b_i[LONG_W-1];
            sr    = raw[LONG_W-1];
        end else begin
            sum_o = raw;
            sa    = a_sc[DATA_W-1];
            sb    = b_i[DATA_W-1];
            sr    = raw[DATA_W-1];
        end
        // subtract flips the sign test on B
        ovf_o = ctl_i.trap && ((sa ^ sb) == ctl_i.sub) && (sr != sa);
    end

endmodule

// File: rtl/ialu_compare.sv
module ialu_compare
    import ialu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8
) (
    input  op_kind_e          kind_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);

    localparam int LANES = DATA_W / BYTE_W;

    logic [LANES-1:0] lane_ge;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_ge[i] = a_i[i*BYTE_W +: BYTE_W] >= b_i[i*BYTE_W +: BYTE_W];
    end

    logic eq, slt, ult;

    always_comb begin
        eq  = (a_i == b_i);
        slt = ($signed(a_i) < $signed(b_i));
        ult = (a_i < b_i);
        res_o = '0;
        unique case (kind_i)
            OP_EQ:     res_o[0] = eq;
            OP_SLT:    res_o[0] = slt;
            OP_SLE:    res_o[0] = slt | eq;
            OP_ULT:    res_o[0] = ult;
            OP_ULE:    res_o[0] = ult | eq;
            OP_BYTEGE: res_o[LANES-1:0] = lane_ge;
            default:   res_o = '0;
        endcase
    end

endmodule

// File: rtl/int_arith_unit.sv
module int_arith_unit
    import ialu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LONG_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        func_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o,
    output logic              illegal_o
);

    localparam int LANES = DATA_W / BYTE_W;

    op_ctl_t           ctl;
    logic [DATA_W-1:0] arith_res, cmp_res, res_d;
    logic              arith_ovf, ovf_d, ill_d;

    ialu_decode u_dec (
        .func_i (func_i),
        .ctl_o  (ctl)
    );

    ialu_addsub #(.DATA_W(DATA_W), .LONG_W(LONG_W)) u_add (
        .ctl_i (ctl),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sum_o (arith_res),
        .ovf_o (arith_ovf)
    );

    ialu_compare #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_cmp (
        .kind_i (ctl.kind),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .res_o  (cmp_res)
    );

    always_comb begin
        res_d = '0;
        ovf_d = 1'b0;
        ill_d = 1'b0;
        case (ctl.kind)
            OP_ARITH: begin
                res_d = arith_res;
                ovf_d = arith_ovf;
            end
            OP_BAD:  ill_d = 1'b1;
            default: res_d = cmp_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            ovf_o     <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= res_d;
            ovf_o     <= ovf_d;
            illegal_o <= ill_d;
        end
    end

    // R9: an illegal code leaves no result and no trap
    a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (result_o == '0 && !ovf_o));

    // R10: only the trapping codes can raise overflow
    a_r10_ovf_trap_only: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ($past(func_i) inside {7'h40, 7'h49, 7'h60, 7'h69}));

    // R6 / R7: compares produce 0 or 1
    a_r6_cmp_boolean: assert property (@(posedge clk) disable iff (rst)
        ($past(func_i) inside {7'h2D, 7'h4D, 7'h6D, 7'h1D, 7'h3D})
        |-> (result_o[DATA_W-1:1] == '0));

    // R8: byte compare leaves bits above the lane mask clear
    a_r8_mask_upper: assert property (@(posedge clk) disable iff (rst)
        ($past(func_i) == 7'h0F) |-> (result_o[DATA_W-1:LANES] == '0));

    // R1: 32-bit forms are sign-extended from bit LONG_W-1
    a_r1_long_sext: assert property (@(posedge clk) disable iff (rst)
        ($past(func_i) inside {7'h00, 7'h40, 7'h02, 7'h12, 7'h09, 7'h49, 7'h0B, 7'h1B})
        |-> (result_o[DATA_W-1:LONG_W-1] == '0 || (&result_o[DATA_W-1:LONG_W-1])));

endmodule

// File: tb/int_arith_unit_test.sv
module int_arith_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  func = '0;
    logic [63:0] opa = '0, opb = '0;
    logic [63:0] res;
    logic        ovf, ill;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    int_arith_unit uut (
        .clk       (clk),
        .rst       (rst),
        .func_i    (func),
        .opa_i     (opa),
        .opb_i     (opb),
        .result_o  (res),
        .ovf_o     (ovf),
        .illegal_o (ill)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [6:0]  f;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] r;
        logic        ov;
        logic        il;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        // R1 plain add
        '{4'd1, 7'h00, 64'h0000_0000_7FFF_FFFF, 64'h1, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0},
        '{4'd1, 7'h20, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF, 64'h0000_0001_FFFF_FFFF, 1'b0, 1'b0},
        // R4 trapping add
        '{4'd4, 7'h40, 64'h0000_0000_7FFF_FFFF, 64'h1, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0},
        '{4'd4, 7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 1'b1, 1'b0},
        '{4'd4, 7'h60, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1'b0, 1'b0},
        // R2 plain subtract, upper A bits ignored in 32-bit form
        '{4'd2, 7'h09, 64'h1234_5678_0000_0000, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
        '{4'd2, 7'h29, 64'h5, 64'h7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0},
        // R5 trapping subtract
        '{4'd5, 7'h49, 64'h0000_0000_8000_0000, 64'h1, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0},
        '{4'd5, 7'h69, 64'h0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b0},
        '{4'd5, 7'h69, 64'hA, 64'h3, 64'h7, 1'b0, 1'b0},
        // R3 scaled forms
        '{4'd3, 7'h02, 64'h0000_0000_4000_0001, 64'h3, 64'h7, 1'b0, 1'b0},
        '{4'd3, 7'h12, 64'h0000_0000_1000_0000, 64'h0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0},
        '{4'd3, 7'h22, 64'h3, 64'h5, 64'h11, 1'b0, 1'b0},
        '{4'd3, 7'h32, 64'h2000_0000_0000_0001, 64'h0, 64'h8, 1'b0, 1'b0},
        '{4'd3, 7'h0B, 64'h1, 64'h5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
        '{4'd3, 7'h1B, 64'h2, 64'h1, 64'hF, 1'b0, 1'b0},
        '{4'd3, 7'h2B, 64'h10, 64'h40, 64'h0, 1'b0, 1'b0},
        '{4'd3, 7'h3B, 64'h1, 64'h10, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 1'b0},
        // R7 equality and unsigned compares
        '{4'd7, 7'h2D, 64'hDEAD, 64'hDEAD, 64'h1, 1'b0, 1'b0},
        '{4'd7, 7'h2D, 64'hDEAD, 64'hBEEF, 64'h0, 1'b0, 1'b0},
        '{4'd7, 7'h3D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b0, 1'b0},
        '{4'd7, 7'h3D, 64'h3, 64'h3, 64'h1, 1'b0, 1'b0},
        '{4'd7, 7'h1D, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0},
        '{4'd7, 7'h1D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b0, 1'b0},
        // R6 signed compares
        '{4'd6, 7'h6D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h1, 1'b0, 1'b0},
        '{4'd6, 7'h6D, 64'h5, 64'h5, 64'h1, 1'b0, 1'b0},
        '{4'd6, 7'h4D, 64'h5, 64'h5, 64'h0, 1'b0, 1'b0},
        '{4'd6, 7'h4D, 64'h8000_0000_0000_0000, 64'h1, 64'h1, 1'b0, 1'b0},
        // R8 byte-lane compare
        '{4'd8, 7'h0F, 64'h0102_0304_0506_0708, 64'h0102_0304_0506_0708, 64'hFF, 1'b0, 1'b0},
        '{4'd8, 7'h0F, 64'h00FF_00FF_00FF_00FF, 64'h0100_0100_0100_0100, 64'h55, 1'b0, 1'b0},
        // R9 undefined codes
        '{4'd9, 7'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b1},
        '{4'd9, 7'h7F, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1'b0, 1'b1},
        '{4'd9, 7'h41, 64'h1234, 64'h5678, 64'h0, 1'b0, 1'b1},
        // R10 non-trapping add that wraps leaves overflow low
        '{4'd10, 7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 1'b0, 1'b0}
    };

    task automatic check(input int rq, input logic [63:0] er, input logic eo, input logic ei);
        checks++;
        if (res !== er || ovf !== eo || ill !== ei) begin
            errors++;
            $display("FAIL R%0d: got res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
                     rq, res, ovf, ill, er, eo, ei);
        end
    endtask

    task automatic apply(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
        func = f;
        opa  = a;
        opb  = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R10: reset state, with an overflowing stimulus held during reset
        func = 7'h60;
        opa  = 64'h7FFF_FFFF_FFFF_FFFF;
        opb  = 64'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(10, 64'h0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].f, VEC[i].a, VEC[i].b);
            check(int'(VEC[i].rq), VEC[i].r, VEC[i].ov, VEC[i].il);
        end

        // R10: one-cycle latency, old value held until the edge
        apply(7'h20, 64'h2, 64'h3);
        check(10, 64'h5, 1'b0, 1'b0);
        func = 7'h29;
        opa  = 64'h9;
        opb  = 64'h4;
        #1;
        check(10, 64'h5, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check(10, 64'h5, 1'b0, 1'b0);   // 9 - 4 = 5 as well; now alter to confirm
        apply(7'h29, 64'h9, 64'h2);
        check(2, 64'h7, 1'b0, 1'b0);

        // R4: overflow flag lasts only one cycle
        apply(7'h40, 64'h7FFF_FFFF, 64'h7FFF_FFFF);
        check(4, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0);
        apply(7'h00, 64'h1, 64'h1);
        check(4, 64'h2, 1'b0, 1'b0);

        // R10: reset mid-run clears the outputs
        func = 7'h01;
        rst  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(10, 64'h0, 1'b0, 1'b0);
        rst = 1'b0;

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule